// File: doc/BRIEF.md
# GPIO Port Register Block with Atomic Bit-Masked Writes

This block is the register file for one eight-pin general-purpose I/O port. It uses a small 32-bit register interface: an address, a write strobe with write data, and a read strobe with read data. Three writable per-pin registers control the port. The mode register places a pin under GPIO control. The drive-enable register turns on its output driver. The level register holds the value the pin drives. A fourth, read-only register returns the pin inputs after a two-flop synchronizer.

Each writable register can be reached at two addresses. The plain address replaces the whole low byte. The alias address, which is the plain address plus 0x800, carries an eight-bit mask in write-data bits 15:8. Only the pins selected by that mask take the new values from bits 7:0. Software can therefore change one pin in a single write, with no read-modify-write and no race with other writers. The pad driver is enabled only for a pin whose mode bit and drive-enable bit are both set.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, all three writable registers are 0, `pin_oe` and `pin_out` are 0, and `reg_rdata` is 0.
- R2: A write to a plain address updates the register's bits 7:0 with write-data bits 7:0. The addresses are mode 0x000, drive-enable 0x010 and level 0x020. Write-data bits 31:8 are ignored.
- R3: A write to an alias address (mode 0x800, drive-enable 0x810, level 0x820) changes bit n to write-data bit n only where write-data bit 8+n is 1. Every other bit keeps its value, so a mask of zero changes nothing.
- R4: `pin_oe[n]` is 1 exactly when mode bit n and drive-enable bit n are both 1. `pin_out[n]` equals level bit n when `pin_oe[n]` is 1 and is 0 otherwise. Writing the level before the drive-enable therefore presents the intended value from the first cycle the pin is driven.
- R5: The input register at 0x030 (alias 0x830) returns `pin_in` after two synchronizer flops in bits 7:0. With the read strobe held, a changed input appears on `reg_rdata` on the third rising edge after the change.
- R6: `reg_rdata` is registered. It carries the addressed word on the edge after `reg_rd` is sampled high, and is 0 in any cycle whose preceding edge saw no read. Bits 31:8 always read 0. An alias address reads the same as its plain address, and any undefined address reads 0.
- R7: Writes to the input register, its alias, or any undefined address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 12 | Byte address within the port |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data; on aliases, bits 15:8 form the mask |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| pin_in | input | 8 | Raw pad input levels |
| pin_out | output | 8 | Pad output value |
| pin_oe | output | 8 | Pad driver enable; 0 leaves the pad high-impedance |

## Verification
The hardest condition to create is a masked write in which the mask and data bits disagree pin by pin. Such a write must set some pins, clear others and leave the rest untouched, all in one access, against a register that already holds a mixed pattern. The vector table reaches this by first loading irregular values through plain writes. It then issues alias writes whose masks cover only part of the byte and whose data bits outside the mask are deliberately set. A final pin-level sequence sets the level before the drive-enable and checks the pad value on the first driven cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [2:0] {
    REG_MODE  = 3'd0,
    REG_DRIVE = 3'd1,
    REG_LEVEL = 3'd2,
    REG_SENSE = 3'd3,
    REG_NONE  = 3'd4
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e kind;
    logic      alias_hit;
  } reg_sel_t;

  localparam logic [10:0] OFF_MODE  = 11'h000;
  localparam logic [10:0] OFF_DRIVE = 11'h010;
  localparam logic [10:0] OFF_LEVEL = 11'h020;
  localparam logic [10:0] OFF_SENSE = 11'h030;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  localparam int ALIAS_BIT = ADDR_W - 1;

  function automatic reg_kind_e kind_of(input logic [10:0] off);
    case (off)
      OFF_MODE:  return REG_MODE;
      OFF_DRIVE: return REG_DRIVE;
      OFF_LEVEL: return REG_LEVEL;
      OFF_SENSE: return REG_SENSE;
      default:   return REG_NONE;
    endcase
  endfunction

  always_comb begin
    sel.alias_hit = addr[ALIAS_BIT];
    sel.kind      = kind_of(addr[10:0]);
  end
endmodule

// File: rtl/gpio_masked_reg.sv
module gpio_masked_reg #(
  parameter int NPINS  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              plain_we,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [NPINS-1:0]  q
);
  localparam int MASK_LSB = NPINS;

  function automatic logic [NPINS-1:0] merge_bits(
    input logic [NPINS-1:0] old_v,
    input logic [NPINS-1:0] new_v,
    input logic [NPINS-1:0] sel_v);
    return (old_v & ~sel_v) | (new_v & sel_v);
  endfunction

  logic [NPINS-1:0] data_bits;
  logic [NPINS-1:0] mask_bits;
  logic [NPINS-1:0] q_next;

  assign data_bits = wdata[NPINS-1:0];
  assign mask_bits = wdata[MASK_LSB +: NPINS];

  always_comb begin
    q_next = q;
    if (plain_we)     q_next = data_bits;
    else if (mask_we) q_next = merge_bits(q, data_bits, mask_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  // R2
  plain_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    plain_we |=> q == $past(wdata[NPINS-1:0]));

  // R3
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && !plain_we && wdata[MASK_LSB +: NPINS] == '0) |=> $stable(q));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] raw,
  output logic [NPINS-1:0] synced
);
  logic [NPINS-1:0] stage_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_a <= '0;
      synced  <= '0;
    end else begin
      stage_a <= raw;
      synced  <= stage_a;
    end
  end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int NPINS = 8
) (
  input  logic [NPINS-1:0] mode_q,
  input  logic [NPINS-1:0] drive_q,
  input  logic [NPINS-1:0] level_q,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pad_oe[i]  = mode_q[i] & drive_q[i];
    assign pad_out[i] = pad_oe[i] & level_q[i];
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);
  localparam int NREGS = 3;

  reg_sel_t         sel;
  logic [NPINS-1:0] reg_q [NREGS];
  logic [NPINS-1:0] sense_q;
  logic [NPINS-1:0] mode_q, drive_q, level_q;
  logic [DATA_W-1:0] rd_word;
  logic             sense_write;
  logic             undef_read;

  gpio_addr_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr (reg_addr),
    .sel  (sel)
  );

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    logic hit;
    assign hit = reg_wr && (sel.kind == reg_kind_e'(r));
    gpio_masked_reg #(.NPINS(NPINS), .DATA_W(DATA_W)) reg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .plain_we (hit && !sel.alias_hit),
      .mask_we  (hit && sel.alias_hit),
      .wdata    (reg_wdata),
      .q        (reg_q[r])
    );
  end

  assign mode_q  = reg_q[REG_MODE];
  assign drive_q = reg_q[REG_DRIVE];
  assign level_q = reg_q[REG_LEVEL];

  gpio_in_sync #(.NPINS(NPINS)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (pin_in),
    .synced (sense_q)
  );

  gpio_pad_drive #(.NPINS(NPINS)) pad_i (
    .mode_q  (mode_q),
    .drive_q (drive_q),
    .level_q (level_q),
    .pad_oe  (pin_oe),
    .pad_out (pin_out)
  );

  always_comb begin
    rd_word = '0;
    case (sel.kind)
      REG_MODE:  rd_word[NPINS-1:0] = mode_q;
      REG_DRIVE: rd_word[NPINS-1:0] = drive_q;
      REG_LEVEL: rd_word[NPINS-1:0] = level_q;
      REG_SENSE: rd_word[NPINS-1:0] = sense_q;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word;
    else             reg_rdata <= '0;
  end

  assign sense_write = reg_wr && (sel.kind == REG_SENSE || sel.kind == REG_NONE);
  assign undef_read  = reg_rd && (sel.kind == REG_NONE);

  // R6
  undef_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef_read |=> reg_rdata == '0);

  // R6
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> reg_rdata == '0);

  // R7
  dead_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sense_write |=> ($stable(mode_q) && $stable(drive_q) && $stable(level_q)));

  // R4
  drive_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel.kind == REG_DRIVE && !sel.alias_hit)
      |=> pin_oe == ($past(reg_wdata[NPINS-1:0]) & mode_q));
endmodule

// File: tb/gpio_port_regs_tb_top.sv
module gpio_port_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_port_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {write addr, write data, read addr, expected read}
  localparam int NVEC = 8;
  localparam logic [87:0] VEC [NVEC] = '{
    {12'h000, 32'hFFFF_FF3C, 12'h000, 32'h0000_003C}, // R2 upper bits ignored
    {12'h800, 32'h0000_0F05, 12'h800, 32'h0000_0035}, // R3 partial mask, R6 alias read
    {12'h020, 32'h0000_00A5, 12'h020, 32'h0000_00A5}, // R2 level
    {12'h820, 32'h0000_8001, 12'h020, 32'h0000_0025}, // R3 bit7 cleared, bit0 unmasked
    {12'h810, 32'h0000_00FF, 12'h010, 32'h0000_0000}, // R3 zero mask
    {12'h010, 32'h0000_000F, 12'h810, 32'h0000_000F}, // R2 drive, R6 alias read
    {12'h030, 32'h0000_00FF, 12'h000, 32'h0000_0035}, // R7 input reg write
    {12'h044, 32'h0000_00FF, 12'h044, 32'h0000_0000}  // R7/R6 undefined address
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pin_oe", {24'h0, pin_oe}, 32'h0);
    check("R1 pin_out", {24'h0, pin_out}, 32'h0);
    check("R1 rdata", reg_rdata, 32'h0);
    rst_n = 1'b1;
    do_read(12'h000, rv);  check("R1 mode", rv, 32'h0);
    do_read(12'h020, rv);  check("R1 level", rv, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      do_write(VEC[i][87:76], VEC[i][75:44]);
      do_read(VEC[i][43:32], rv);
      check($sformatf("R2/R3/R6/R7 vec%0d", i), rv, VEC[i][31:0]);
    end

    // R4 mode=35 drive=0F level=25 -> oe=05, out=05
    check("R4 pin_oe", {24'h0, pin_oe}, 32'h05);
    check("R4 pin_out", {24'h0, pin_out}, 32'h05);

    // R6 rdata returns to zero with no read
    @(negedge clk);
    check("R6 idle rdata", reg_rdata, 32'h0);

    // R4 level first, then mode, then drive on pin 6
    do_write(12'h820, 32'h0000_4040);
    check("R4 not driven yet", {31'h0, pin_oe[6]}, 32'h0);
    do_write(12'h800, 32'h0000_4040);
    check("R4 mode only", {31'h0, pin_oe[6]}, 32'h0);
    do_write(12'h810, 32'h0000_4040);
    check("R4 first driven oe", {31'h0, pin_oe[6]}, 32'h1);
    check("R4 first driven out", {31'h0, pin_out[6]}, 32'h1);

    // R5 synchronizer latency with read held
    @(negedge clk);
    pin_in = 8'h5A; reg_addr = 12'h030; reg_rd = 1'b1;
    @(negedge clk);
    check("R5 edge1", reg_rdata, 32'h0);
    @(negedge clk);
    check("R5 edge2", reg_rdata, 32'h0);
    @(negedge clk);
    check("R5 edge3", reg_rdata, 32'h5A);
    reg_rd = 1'b0;
    do_read(12'h830, rv);  check("R5 alias input", rv, 32'h5A);
    do_write(12'h830, 32'h0000_FFFF);
    do_read(12'h010, rv);  check("R7 input alias write", rv, 32'h4F);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule